// File: doc/BRIEF.md
# Multi-Mode Pulse Counter

This block counts pulses from an encoder-style input trio (channels A, B and an index Z) into a signed or wrapping present value. The channels come from outside the clock domain, so they pass through a synchroniser first. Each sample is then compared with the one before it. One of three input encodings is chosen at run time, and each turns channel activity into single up or down steps:
- four-times quadrature,
- separate up and down pulse lines,
- a pulse line with a direction level.

The range behaviour is also set at run time. In saturating linear mode the value is held at the signed limits and a sticky limit flag is raised. In ring mode the value runs from zero to a programmable top value and wraps in both directions.

Clearing is controlled by a software reset level. In one reset source setting, a rising edge of that level clears the counter. In the other, the counter clears only on a rising edge of the index channel while the software level is high. Each clear produces a one-cycle strobe for downstream compare logic.

Top module: `pulse_counter`

## Requirements
- R1: While and after rst_ni is low, count_o, ovf_o, unf_o, quad_err_o and clr_o are all zero.
- R2: With in_mode_i = 2'b00 (quadrature), every single-channel change of the synchronised A/B pair moves the count by one, in the cycle 3 clocks after the input change. The count rises when A leads B (AB sequence 00, 10, 11, 01) and falls for the reverse order.
- R3: In quadrature mode, a sample in which A and B both change leaves the count untouched and sets quad_err_o, which stays set until the next clear.
- R4: With in_mode_i = 2'b01, a rising edge on A adds one and a rising edge on B subtracts one. Rising edges on both in the same sample cancel, and falling edges do nothing.
- R5: With in_mode_i = 2'b10, a rising edge on A adds one when B is low and subtracts one when B is high. Changes on B alone do nothing. in_mode_i = 2'b11 counts nothing.
- R6: With ring_mode_i low, a count at the signed maximum (0 followed by all ones) stays there on an up step and sets the sticky ovf_o.
- R7: With ring_mode_i low, a count at the signed minimum (1 followed by all zeros) stays there on a down step and sets the sticky unf_o.
- R8: With ring_mode_i high, an up step at ring_max_i moves the count to 0, and the count never leaves 0..ring_max_i.
- R9: With ring_mode_i high, a down step at 0 moves the count to ring_max_i.
- R10: With rst_src_i low, the counter clears on the clock where sw_rst_i is first seen high after being low. Holding sw_rst_i high neither clears again nor stops counting, and Z has no effect.
- R11: With rst_src_i high, the counter clears only on a rising edge of synchronised Z while sw_rst_i is high. A Z edge with sw_rst_i low, or a rise of sw_rst_i alone, has no effect.
- R12: On every clear, clr_o is high for exactly one cycle. In that cycle count_o is 0 and ovf_o, unf_o and quad_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Channel A (asynchronous) |
| b_i | input | 1 | Channel B (asynchronous) |
| z_i | input | 1 | Index channel (asynchronous) |
| in_mode_i | input | 2 | Input encoding: 00 quadrature, 01 up/down, 10 pulse+direction, 11 off |
| ring_mode_i | input | 1 | 1 = ring range, 0 = saturating signed linear range |
| ring_max_i | input | CNT_W | Top value of the ring range |
| rst_src_i | input | 1 | 0 = software level edge clears, 1 = Z edge qualified by software level |
| sw_rst_i | input | 1 | Software reset level |
| count_o | output | CNT_W | Present value |
| ovf_o | output | 1 | Sticky linear overflow |
| unf_o | output | 1 | Sticky linear underflow |
| quad_err_o | output | 1 | Sticky invalid quadrature transition |
| clr_o | output | 1 | One-cycle clear strobe |

## Verification
The bench builds the counter with CNT_W = 8. With that width both signed limits (127 and -128) are only about 130 pulses away from zero, so saturation and the sticky limit flags are tested directly rather than by inference. The ring top value is set to 5, which brings wrap-around in both directions within a few pulses. The synchroniser keeps its default depth of two, so the three-clock input-to-count latency of the default build is the one compared on every clock.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    IN_QUAD = 2'b00,
    IN_UPDN = 2'b01,
    IN_PDIR = 2'b10,
    IN_OFF  = 2'b11
  } in_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic bad;
  } step_t;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
  import pcnt_pkg::*;
(
  input  in_mode_e mode_i,
  input  logic     a_cur_i,
  input  logic     b_cur_i,
  input  logic     a_prv_i,
  input  logic     b_prv_i,
  output step_t    step_o
);
  logic a_chg, b_chg, a_rise, b_rise;

  assign a_chg  = a_cur_i ^ a_prv_i;
  assign b_chg  = b_cur_i ^ b_prv_i;
  assign a_rise = a_cur_i & ~a_prv_i;
  assign b_rise = b_cur_i & ~b_prv_i;

  always_comb begin
    step_o = '0;
    unique case (mode_i)
      IN_QUAD: begin
        if (a_chg && b_chg) begin
          step_o.bad = 1'b1;
        end else if (a_chg) begin
          step_o.up = (a_cur_i != b_cur_i);
          step_o.dn = (a_cur_i == b_cur_i);
        end else if (b_chg) begin
          step_o.up = (b_cur_i == a_cur_i);
          step_o.dn = (b_cur_i != a_cur_i);
        end
      end
      IN_UPDN: begin
        step_o.up = a_rise & ~b_rise;
        step_o.dn = b_rise & ~a_rise;
      end
      IN_PDIR: begin
        step_o.up = a_rise & ~b_cur_i;
        step_o.dn = a_rise &  b_cur_i;
      end
      default: step_o = '0;
    endcase
  end
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_t            step_i,
  input  logic             clear_i,
  input  logic             ring_i,
  input  logic [CNT_W-1:0] ring_max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             err_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] LIN_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LIN_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      err_o <= 1'b0;
      clr_o <= 1'b0;
    end else begin
      clr_o <= clear_i;
      if (clear_i) begin
        cnt_o <= '0;
        ovf_o <= 1'b0;
        unf_o <= 1'b0;
        err_o <= 1'b0;
      end else begin
        if (step_i.bad) err_o <= 1'b1;
        if (step_i.up) begin
          if (ring_i)                cnt_o <= (cnt_o >= ring_max_i) ? '0 : cnt_o + ONE;
          else if (cnt_o == LIN_MAX) ovf_o <= 1'b1;
          else                       cnt_o <= cnt_o + ONE;
        end else if (step_i.dn) begin
          if (ring_i)                cnt_o <= (cnt_o == '0) ? ring_max_i : cnt_o - ONE;
          else if (cnt_o == LIN_MIN) unf_o <= 1'b1;
          else                       cnt_o <= cnt_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_counter.sv
module pulse_counter
  import pcnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             z_i,
  input  logic [1:0]       in_mode_i,
  input  logic             ring_mode_i,
  input  logic [CNT_W-1:0] ring_max_i,
  input  logic             rst_src_i,
  input  logic             sw_rst_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             quad_err_o,
  output logic             clr_o
);
  localparam int NCH = 3;

  logic [NCH-1:0] raw, syn, prv_q;
  logic           sw_prv_q, z_rise, clear;
  step_t          step;

  assign raw = {z_i, b_i, a_i};

  pcnt_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_q    <= '0;
      sw_prv_q <= 1'b0;
    end else begin
      prv_q    <= syn;
      sw_prv_q <= sw_rst_i;
    end
  end

  pcnt_decode u_dec (
    .mode_i (in_mode_e'(in_mode_i)),
    .a_cur_i(syn[0]),
    .b_cur_i(syn[1]),
    .a_prv_i(prv_q[0]),
    .b_prv_i(prv_q[1]),
    .step_o (step)
  );

  assign z_rise = syn[2] & ~prv_q[2];
  assign clear  = rst_src_i ? (z_rise & sw_rst_i) : (sw_rst_i & ~sw_prv_q);

  pcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .clear_i   (clear),
    .ring_i    (ring_mode_i),
    .ring_max_i(ring_max_i),
    .cnt_o     (count_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o),
    .err_o     (quad_err_o),
    .clr_o     (clr_o)
  );
endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ring_mode_i,
  input logic [CNT_W-1:0] ring_max_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             quad_err_o,
  input logic             clr_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_clr_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);

  assert_clr_state_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> (count_o == '0) && !ovf_o && !unf_o && !quad_err_o);

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (ovf_o || clr_o));

  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> (unf_o || clr_o));

  assert_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_err_o |=> (quad_err_o || clr_o));

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ring_mode_i && !clr_o) |->
      (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE) ||
      (count_o == $past(count_o) - ONE));

  assert_ring_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_mode_i && $past(ring_mode_i) && $stable(ring_max_i) &&
     ($past(count_o) <= $past(ring_max_i))) |-> (count_o <= ring_max_i));
endmodule

bind pulse_counter pcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ring_mode_i(ring_mode_i),
  .ring_max_i (ring_max_i),
  .count_o    (count_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .quad_err_o (quad_err_o),
  .clr_o      (clr_o)
);

// File: tb/pulse_counter_tb.sv
module pulse_counter_tb;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         a_i = 0, b_i = 0, z_i = 0;
  logic [1:0]   in_mode_i = 2'b11;
  logic         ring_mode_i = 0;
  logic [W-1:0] ring_max_i = 8'd5;
  logic         rst_src_i = 0, sw_rst_i = 0;
  logic [W-1:0] count_o;
  logic         ovf_o, unf_o, quad_err_o, clr_o;

  int    errors = 0, checks = 0;
  bit    done = 0;
  string req = "R1";

  always #2 clk_i = ~clk_i;

  pulse_counter #(.CNT_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .z_i(z_i),
    .in_mode_i(in_mode_i), .ring_mode_i(ring_mode_i), .ring_max_i(ring_max_i),
    .rst_src_i(rst_src_i), .sw_rst_i(sw_rst_i), .count_o(count_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .quad_err_o(quad_err_o), .clr_o(clr_o)
  );

  // reference model: sample history (index = edges ago), integer arithmetic
  bit           ha[1:3], hb[1:3], hz[1:3];
  bit           m_swp;
  logic [W-1:0] m_cnt;
  bit           m_ovf, m_unf, m_err, m_clr;

  function automatic int gray_pos(bit a, bit b);
    return (!a && !b) ? 0 : (a && !b) ? 1 : (a && b) ? 2 : 3;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= 3; i++) begin ha[i] = 0; hb[i] = 0; hz[i] = 0; end
      m_swp = 0; m_cnt = '0; m_ovf = 0; m_unf = 0; m_err = 0; m_clr = 0;
    end else begin
      int  delta, v, d;
      bit  clr;
      delta = 0;
      case (in_mode_i)
        2'b00: begin
          d = (gray_pos(ha[2], hb[2]) - gray_pos(ha[3], hb[3]) + 4) % 4;
          if (d == 1) delta = 1;
          else if (d == 3) delta = -1;
          else if (d == 2) m_err = 1;
        end
        2'b01: delta = int'(ha[2] && !ha[3]) - int'(hb[2] && !hb[3]);
        2'b10: if (ha[2] && !ha[3]) delta = hb[2] ? -1 : 1;
        default: delta = 0;
      endcase
      clr = rst_src_i ? (hz[2] && !hz[3] && sw_rst_i) : (sw_rst_i && !m_swp);
      m_clr = clr;
      if (clr) begin
        m_cnt = '0; m_ovf = 0; m_unf = 0; m_err = 0;
      end else if (delta != 0) begin
        if (ring_mode_i) begin
          v = int'(m_cnt) + delta;
          if (v > int'(ring_max_i)) v = 0;
          if (v < 0) v = int'(ring_max_i);
          m_cnt = v[W-1:0];
        end else begin
          v = int'($signed(m_cnt)) + delta;
          if (v > 2**(W-1) - 1) begin v = 2**(W-1) - 1; m_ovf = 1; end
          if (v < -(2**(W-1))) begin v = -(2**(W-1)); m_unf = 1; end
          m_cnt = v[W-1:0];
        end
      end
      m_swp = sw_rst_i;
      ha[3] = ha[2]; ha[2] = ha[1]; ha[1] = a_i;
      hb[3] = hb[2]; hb[2] = hb[1]; hb[1] = b_i;
      hz[3] = hz[2]; hz[2] = hz[1]; hz[1] = z_i;
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      checks++;
      if (count_o !== m_cnt || ovf_o !== m_ovf || unf_o !== m_unf ||
          quad_err_o !== m_err || clr_o !== m_clr) begin
        errors++;
        $display("FAIL %s: cnt=%h ovf=%b unf=%b err=%b clr=%b expected cnt=%h ovf=%b unf=%b err=%b clr=%b",
                 req, count_o, ovf_o, unf_o, quad_err_o, clr_o,
                 m_cnt, m_ovf, m_unf, m_err, m_clr);
      end
    end
  end

  task automatic expect_state(string tag, int cnt, bit ovf, bit unf, bit err);
    logic [W-1:0] exp_c;
    exp_c = cnt[W-1:0];
    checks++;
    if (count_o !== exp_c || ovf_o !== ovf || unf_o !== unf || quad_err_o !== err) begin
      errors++;
      $display("FAIL %s: cnt=%h ovf=%b unf=%b err=%b expected cnt=%h ovf=%b unf=%b err=%b",
               tag, count_o, ovf_o, unf_o, quad_err_o, exp_c, ovf, unf, err);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  int qpos = 0;
  task automatic quad_move(int n, bit fwd);
    for (int i = 0; i < n; i++) begin
      qpos = fwd ? (qpos + 1) % 4 : (qpos + 3) % 4;
      a_i = (qpos == 1 || qpos == 2);
      b_i = (qpos == 2 || qpos == 3);
      wait_n(3);
    end
  endtask

  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin a_i = 1; wait_n(3); a_i = 0; wait_n(3); end
  endtask

  task automatic pulse_b(int n);
    for (int i = 0; i < n; i++) begin b_i = 1; wait_n(3); b_i = 0; wait_n(3); end
  endtask

  task automatic pulse_z();
    z_i = 1; wait_n(4); z_i = 0; wait_n(4);
  endtask

  task automatic sw_edge();
    sw_rst_i = 0; wait_n(2); sw_rst_i = 1; wait_n(4);
  endtask

  initial begin
    wait_n(3);
    expect_state("R1 in reset", 0, 0, 0, 0);
    rst_ni = 1;
    wait_n(2);
    expect_state("R1 after reset", 0, 0, 0, 0);
    if (clr_o !== 1'b0) begin errors++; $display("FAIL R1: clr=%b expected 0", clr_o); end
    checks++;

    req = "R2"; in_mode_i = 2'b00;
    quad_move(8, 1); wait_n(4);
    expect_state("R2 forward 8", 8, 0, 0, 0);
    quad_move(3, 0); wait_n(4);
    expect_state("R2 reverse 3", 5, 0, 0, 0);

    req = "R3";
    qpos = (qpos + 2) % 4;
    a_i = (qpos == 1 || qpos == 2); b_i = (qpos == 2 || qpos == 3);
    wait_n(5);
    expect_state("R3 double change", 5, 0, 0, 1);
    quad_move(1, 1); wait_n(4);
    expect_state("R3 sticky error", 6, 0, 0, 1);

    in_mode_i = 2'b11; a_i = 0; b_i = 0; qpos = 0; wait_n(5);
    expect_state("R5 off mode", 6, 0, 0, 1);

    req = "R10"; rst_src_i = 0;
    sw_edge();
    expect_state("R10 sw edge clears", 0, 0, 0, 0);

    req = "R4"; in_mode_i = 2'b01;
    pulse_a(3); pulse_b(1);
    a_i = 1; b_i = 1; wait_n(3); a_i = 0; b_i = 0; wait_n(4);
    expect_state("R4 up/down with held sw R10", 2, 0, 0, 0);

    req = "R10";
    pulse_z();
    expect_state("R10 Z ignored", 2, 0, 0, 0);
    sw_rst_i = 0; wait_n(2);

    req = "R5"; in_mode_i = 2'b10;
    pulse_a(2);
    b_i = 1; wait_n(4);
    pulse_a(3);
    b_i = 0; wait_n(3); b_i = 1; wait_n(3); b_i = 0; wait_n(4);
    expect_state("R5 pulse+dir", 1, 0, 0, 0);

    req = "R6"; in_mode_i = 2'b01;
    pulse_a(130); wait_n(2);
    expect_state("R6 saturate high", 127, 1, 0, 0);

    req = "R12";
    sw_edge();
    expect_state("R12 clear drops ovf", 0, 0, 0, 0);
    sw_rst_i = 0; wait_n(2);

    req = "R7";
    pulse_b(130); wait_n(2);
    expect_state("R7 saturate low", -128, 0, 1, 0);

    req = "R11"; rst_src_i = 1;
    sw_edge();
    expect_state("R11 sw alone ignored", -128, 0, 1, 0);
    sw_rst_i = 0; wait_n(2);
    pulse_z();
    expect_state("R11 Z without sw ignored", -128, 0, 1, 0);
    sw_rst_i = 1; wait_n(2);
    pulse_z();
    expect_state("R11 Z with sw clears", 0, 0, 0, 0);

    req = "R8"; ring_mode_i = 1;
    pulse_a(7); wait_n(2);
    expect_state("R8 ring wrap up", 1, 0, 0, 0);

    req = "R9";
    pulse_b(3); wait_n(2);
    expect_state("R9 ring wrap down", 4, 0, 0, 0);

    wait_n(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule